// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one parallel character into a frame on a single serial line. A frame is a low start bit, then the data bits least significant first, then an optional parity bit, then a high stop period. A six-bit framing word picks the word length (5 to 8 bits), the stop length, whether parity is sent, and which parity is sent: odd, even, or a constant mark or space.

Timing comes from a one-cycle enable pulse at sixteen times the bit rate, so each bit lasts sixteen pulses. The block samples the framing word and the data byte together when a character is loaded, and holds them until the frame ends. A busy flag stays high until the final stop pulse. Any load that arrives while busy is high is dropped.

Top module: `sertx_frame`

## Requirements
- R1: While idle the line `txd` is high and `busy` is low; reset forces this state at once, even in the middle of a frame.
- R2: A `load` pulse while `busy` is low makes `busy` high and drives `txd` low (the start bit) from the next clock. The start bit lasts 16 ticks.
- R3: The data bits follow the start bit least significant bit first, 16 ticks each. `line_cfg[1:0]` sets the count (00=5, 01=6, 10=7, 11=8), and data bits above that count are ignored.
- R4: With `line_cfg[3]`=0 no parity bit is sent, whatever `line_cfg[5:4]` holds.
- R5: With `line_cfg[3]`=1 and `line_cfg[5]`=0, the parity bit gives an odd count of ones over the data and parity bits when `line_cfg[4]`=0, and an even count when `line_cfg[4]`=1.
- R6: With `line_cfg[3]`=1 and `line_cfg[5]`=1, the parity bit is a constant: 1 when `line_cfg[4]`=0, 0 when `line_cfg[4]`=1.
- R7: The stop period holds `txd` high. It lasts 16 ticks when `line_cfg[2]`=0. When `line_cfg[2]`=1 it lasts 24 ticks for 5-bit words and 32 ticks for 6, 7 and 8-bit words.
- R8: `busy` stays high through the last stop tick and falls on that tick's clock edge. A `load` seen while `busy` is high is ignored, and this includes the cycle of the last stop tick.
- R9: `line_cfg` and `tx_data` are captured on the accepted load. Changing them during a frame has no effect on that frame.
- R10: The frame advances only on clocks where `tick16` is high. After a load, `txd` changes only on such clocks, and `busy` falls only on such clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| line_cfg | input | 6 | Framing word: [1:0] length, [2] long stop, [3] parity on, [4] parity sense, [5] constant parity |
| tx_data | input | 8 | Character to send |
| load | input | 1 | Starts a frame when `busy` is low |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | High from the load until the last stop tick |

## Verification
Two events can land in the same cycle: a new `load` and the final stop tick that ends the previous frame. The bench raises `load` on exactly the clock where the last stop tick falls. It then checks that `busy` goes low on schedule and stays low, and that the line stays high for twenty cycles afterwards, which shows that the load was dropped. A second injection changes the data and the framing word in the middle of a frame together with a load pulse, and the bench compares the sampled frame bit for bit with the frame it expects from the original load.

// File: rtl/sertx_frame.sv
module sertx_frame #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic [5:0] line_cfg,
  input  logic [7:0] tx_data,
  input  logic       load,
  output logic       txd,
  output logic       busy
);
  localparam int SLOT_W = $clog2(2 * TICKS_PER_BIT);
  localparam logic [SLOT_W-1:0] LAST_ONE  = SLOT_W'(TICKS_PER_BIT - 1);
  localparam logic [SLOT_W-1:0] LAST_HALF = SLOT_W'((3 * TICKS_PER_BIT) / 2 - 1);
  localparam logic [SLOT_W-1:0] LAST_TWO  = SLOT_W'(2 * TICKS_PER_BIT - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} phase_t;

  phase_t            phase;
  logic [SLOT_W-1:0] tcnt;
  logic [SLOT_W-1:0] stop_last;
  logic [2:0]        bitn;
  logic [2:0]        wlast;
  logic [7:0]        sh;
  logic              par_en;
  logic              par_bit;

  logic [7:0]        mask;
  logic              ones_odd;
  logic              par_new;
  logic [SLOT_W-1:0] stop_new;
  logic [SLOT_W-1:0] slot_last;
  logic              slot_end;
  logic              accept;

  assign mask     = 8'hFF >> (2'd3 - line_cfg[1:0]);
  assign ones_odd = ^(tx_data & mask);
  assign par_new  = line_cfg[5] ? ~line_cfg[4] : (line_cfg[4] ? ones_odd : ~ones_odd);
  assign stop_new = !line_cfg[2] ? LAST_ONE : (line_cfg[1:0] == 2'd0 ? LAST_HALF : LAST_TWO);

  assign busy      = (phase != S_IDLE);
  assign accept    = load && !busy;
  assign slot_last = (phase == S_STOP) ? stop_last : LAST_ONE;
  assign slot_end  = tick16 && busy && (tcnt == slot_last);

  always_comb begin
    case (phase)
      S_START: txd = 1'b0;
      S_DATA:  txd = sh[0];
      S_PAR:   txd = par_bit;
      default: txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= S_IDLE;
      tcnt      <= '0;
      stop_last <= LAST_ONE;
      bitn      <= '0;
      wlast     <= 3'd4;
      sh        <= '0;
      par_en    <= 1'b0;
      par_bit   <= 1'b1;
    end else if (accept) begin
      phase     <= S_START;
      tcnt      <= '0;
      stop_last <= stop_new;
      bitn      <= '0;
      wlast     <= 3'd4 + {1'b0, line_cfg[1:0]};
      sh        <= tx_data;
      par_en    <= line_cfg[3];
      par_bit   <= par_new;
    end else if (tick16 && busy) begin
      if (!slot_end) begin
        tcnt <= tcnt + 1'b1;
      end else begin
        tcnt <= '0;
        case (phase)
          S_START: phase <= S_DATA;
          S_DATA: begin
            sh <= sh >> 1;
            if (bitn == wlast) phase <= par_en ? S_PAR : S_STOP;
            else bitn <= bitn + 1'b1;
          end
          S_PAR:   phase <= S_STOP;
          default: phase <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sertx_frame_chk.sv
module sertx_frame_chk (
  input logic clk,
  input logic rst_n,
  input logic tick16,
  input logic load,
  input logic txd,
  input logic busy
);
  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  a_r2_load_starts_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !busy) |=> (busy && !txd));

  a_r1_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load) |=> !busy);

  a_r10_busy_falls_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick16) |=> busy);

  a_r10_line_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick16) |=> $stable(txd));

  a_r8_load_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && load && !tick16) |=> (busy && $stable(txd)));
endmodule

bind sertx_frame sertx_frame_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .load(load), .txd(txd), .busy(busy)
);

// File: tb/sim_sertx_frame.sv
`timescale 1ns/1ps
module sim_sertx_frame;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b1;
  logic       tick_alt = 1'b0;
  logic [5:0] line_cfg = 6'd0;
  logic [7:0] tx_data = 8'd0;
  logic       load = 1'b0;
  logic       txd;
  logic       busy;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  always @(negedge clk) tick16 <= tick_alt ? ~tick16 : 1'b1;

  sertx_frame u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .line_cfg(line_cfg),
    .tx_data(tx_data), .load(load), .txd(txd), .busy(busy)
  );

  // {cfg[5:0], data[7:0], expected parity, expected stop ticks[5:0]}
  localparam int NV = 10;
  localparam logic [20:0] VEC [NV] = '{
    {6'b000011, 8'hA5, 1'b0, 6'd16},
    {6'b001011, 8'hA5, 1'b1, 6'd16},
    {6'b011011, 8'hA5, 1'b0, 6'd16},
    {6'b000100, 8'hFF, 1'b0, 6'd24},
    {6'b001100, 8'h07, 1'b0, 6'd24},
    {6'b011001, 8'hC1, 1'b1, 6'd16},
    {6'b101010, 8'h00, 1'b1, 6'd16},
    {6'b111111, 8'hFF, 1'b0, 6'd32},
    {6'b001110, 8'h80, 1'b1, 6'd32},
    {6'b110001, 8'h3F, 1'b0, 6'd16}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // inj: 0 none, 1 mid-frame load with altered data/cfg, 2 load on last stop tick
  task automatic run_frame(input logic [20:0] v, input int inj);
    logic [5:0] c; logic [7:0] d; logic ep; int es, w, p, nb, total, quiet;
    logic [11:0] expv, got, m;
    c = v[20:15]; d = v[14:7]; ep = v[6]; es = int'(v[5:0]);
    w = 5 + int'(c[1:0]); p = int'(c[3]); nb = 1 + w + p; total = 16 * nb + es;
    expv = '0; got = '0;
    for (int j = 0; j < w; j++) expv[1 + j] = d[j];
    if (p == 1) expv[1 + w] = ep;
    m = (12'd1 << nb) - 12'd1;
    @(negedge clk); line_cfg = c; tx_data = d; load = 1'b1;
    @(negedge clk); load = 1'b0;
    for (int i = 0; i <= total; i++) begin
      if (i > 0) @(negedge clk);
      if (i < 16 * nb && (i % 16) == 8) got[i / 16] = txd;
      if (i == 16 * nb + es / 2) check(txd == 1'b1, "R7 stop level", int'(txd), 1);
      if (i == total - 1) check(busy == 1'b1, "R8 busy through last stop tick", int'(busy), 1);
      if (i == total) check(busy == 1'b0, "R7 stop length", int'(busy), 0);
      if (inj == 1 && i == 40) begin load = 1'b1; tx_data = ~d; line_cfg = ~c; end
      if (inj == 1 && i == 41) load = 1'b0;
      if (inj == 2 && i == total - 1) load = 1'b1;
      if (inj == 2 && i == total) load = 1'b0;
    end
    check((got & m) == (expv & m), "R3 R4 R5 R6 R9 frame bits", int'(got & m), int'(expv & m));
    if (inj == 2) begin
      quiet = 1;
      repeat (20) begin
        @(negedge clk);
        if (busy || !txd) quiet = 0;
      end
      check(quiet == 1, "R8 load on last stop tick ignored", quiet, 1);
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(txd == 1'b1 && busy == 1'b0, "R1 reset state", {txd, busy}, 2'b10);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(txd == 1'b1 && busy == 1'b0, "R1 idle after reset", {txd, busy}, 2'b10);

    for (int k = 0; k < NV; k++) run_frame(VEC[k], 0);

    // R2: start bit on the clock after load
    @(negedge clk); line_cfg = 6'b000011; tx_data = 8'hFF; load = 1'b1;
    @(negedge clk); load = 1'b0;
    check(busy == 1'b1 && txd == 1'b0, "R2 start after load", {busy, txd}, 2'b10);
    repeat (200) @(negedge clk);

    // R9 + R8: mid-frame load with changed inputs is ignored
    run_frame({6'b001011, 8'h5A, 1'b1, 6'd16}, 1);
    // R8: load on the cycle of the final stop tick
    run_frame({6'b000100, 8'h13, 1'b0, 6'd24}, 2);

    // R10: tick every other clock doubles the frame time (8N1 = 160 ticks)
    tick_alt = 1'b1;
    @(negedge clk); line_cfg = 6'b000011; tx_data = 8'h96; load = 1'b1;
    @(negedge clk); load = 1'b0;
    n = 0;
    while (busy && n < 1000) begin @(negedge clk); n++; end
    check(n >= 318 && n <= 321, "R10 tick gating", n, 320);
    tick_alt = 1'b0;
    repeat (4) @(negedge clk);

    // R1: reset in mid-frame
    @(negedge clk); line_cfg = 6'b001011; tx_data = 8'h00; load = 1'b1;
    @(negedge clk); load = 1'b0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(txd == 1'b1 && busy == 1'b0, "R1 reset mid-frame", {txd, busy}, 2'b10);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule